// File: doc/BRIEF.md
# Dual-bus CAN repeater logic

This block is the digital routing core between one CAN protocol controller and two physical bus transceivers. Every data pin is active-low: a 0 is dominant and a 1 is recessive. It merges dominant levels from the local transmit input, an expansion transmit input and the two receiver comparators. It forwards the merged level to both bus drivers and to two receive outputs, and no source has priority over another. The expansion pair lets several of these cores be chained so that more than two buses behave as one logical bus.

Each bus can be switched off with its own active-low enable. A disabled bus neither drives nor listens. When the block drives a bus dominant, it masks that bus's receiver. The mask stays on for a programmable number of clock cycles after the drive ends. Without this mask, a level forwarded from one bus would be echoed back and would hold both buses dominant for ever. A thermal-shutdown input turns off both drivers and leaves the receive side working.

Top module: `dual_can_rep`

## Requirements
- R1: Dominant is 0 and recessive is 1 on every data pin. After reset, with all inputs high and both buses enabled, both driver requests and both receive outputs stay at 1.
- R2: While `tx_n_i` or `xtx_n_i` is 0, `tsd_i` is 0 and `en_n_i[k]` is 0, `drv_n_o[k]` is 0 one clock edge later.
- R3: A 0 on `rx_cmp_n_i[k]` of an enabled bus whose receiver is not masked makes `rx_n_o` and `xrx_n_o` 0 in the same cycle, and makes the other bus's `drv_n_o` 0 one clock edge later.
- R4: With `en_n_i[k]` at 1, `drv_n_o[k]` is 1 from the next clock edge, and a 0 on `rx_cmp_n_i[k]` does not affect any output.
- R5: A 0 on `tx_n_i` makes both `rx_n_o` and `xrx_n_o` 0 in the same cycle, whatever the enables are set to.
- R6: A 0 on `xtx_n_i` makes `rx_n_o` 0 in the same cycle, whatever the enables are set to. It does not affect `xrx_n_o`, which stays 1 when nothing else is dominant.
- R7: While `tsd_i` is 1, both driver requests are 1 from the next clock edge. The receive outputs still follow the transmit inputs and the enabled comparators.
- R8: A bus's receiver is ignored while its `drv_n_o` is 0, and for `REL_CYC` clock cycles after that output returns to 1.
- R9: A single dominant pulse of N cycles on bus 0's comparator produces exactly one pulse of N cycles on `drv_n_o[1]`, one cycle later. It produces no pulse on `drv_n_o[0]`, and both buses are recessive afterwards.
- R10: While `rst_ni` is 0, both driver requests are 1 and both receive outputs are 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_n_i | input | 1 | Local transmit data from the protocol controller, 0 = dominant |
| xtx_n_i | input | 1 | Expansion transmit data from a chained core, 0 = dominant |
| en_n_i | input | 2 | Per-bus enable, 0 = enabled; bit k controls bus k |
| rx_cmp_n_i | input | 2 | Per-bus receiver comparator result, 0 = dominant seen |
| tsd_i | input | 1 | Thermal shutdown, 1 = drivers off |
| drv_n_o | output | 2 | Per-bus driver request, 0 = drive dominant |
| rx_n_o | output | 1 | Local receive data to the protocol controller |
| xrx_n_o | output | 1 | Expansion receive data to a chained core |

## Verification
Driver requests are registered, so a stimulus applied before a clock edge shows on `drv_n_o` from that edge on. Both receive outputs are combinational from the inputs and from the registered driver and mask state, so they are due in the cycle of the stimulus. The receiver mask opens exactly `REL_CYC` edges after a driver request returns to 1. The bench changes inputs only after a compare point. It lets one rising edge pass and then compares every output half a period later against a behavioural model. The model is advanced at that same edge, so each result is read in the cycle it is due. The bus comparators are modelled as the wired combination of the block's own driver and an external node, which makes the echo path real.

// File: rtl/rep_pkg.sv
package rep_pkg;
  localparam int unsigned NBUS = 2;
  typedef logic [NBUS-1:0] bus_t;
endpackage

// File: rtl/rep_rx_gate.sv
module rep_rx_gate #(
  parameter int unsigned REL_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_dom_i,
  input  logic drv_q_i,
  input  logic drv_d_i,
  output logic rcv_o
);
  localparam int unsigned CW = $clog2(REL_CYC + 1);

  logic [CW-1:0] hold_q;
  logic          mask;

  // reload when the driver releases; count down to reopen the receiver
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 hold_q <= '0;
    else if (drv_q_i && !drv_d_i) hold_q <= CW'(REL_CYC);
    else if (hold_q != '0)       hold_q <= hold_q - CW'(1);
  end

  assign mask  = drv_q_i | (hold_q != '0);
  assign rcv_o = en_i & cmp_dom_i & ~mask;
endmodule

// File: rtl/rep_merge.sv
module rep_merge
  import rep_pkg::*;
(
  input  logic tx_dom_i,
  input  logic xtx_dom_i,
  input  bus_t en_i,
  input  logic tsd_i,
  input  bus_t rcv_i,
  output bus_t drv_d_o,
  output logic rx_dom_o,
  output logic xrx_dom_o
);
  logic any_rcv;
  assign any_rcv = |rcv_i;

  for (genvar k = 0; k < NBUS; k++) begin : g_drv
    bus_t others;
    always_comb begin
      others    = rcv_i;
      others[k] = 1'b0;
    end
    assign drv_d_o[k] = en_i[k] & ~tsd_i & (tx_dom_i | xtx_dom_i | (|others));
  end

  assign rx_dom_o  = tx_dom_i | xtx_dom_i | any_rcv;
  assign xrx_dom_o = tx_dom_i | any_rcv;
endmodule

// File: rtl/rep_drv_reg.sv
module rep_drv_reg
  import rep_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  bus_t d_i,
  output bus_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/dual_can_rep.sv
module dual_can_rep
  import rep_pkg::*;
#(
  parameter int unsigned REL_CYC = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_n_i,
  input  logic       xtx_n_i,
  input  logic [1:0] en_n_i,
  input  logic [1:0] rx_cmp_n_i,
  input  logic       tsd_i,
  output logic [1:0] drv_n_o,
  output logic       rx_n_o,
  output logic       xrx_n_o
);
  bus_t en, cmp_dom, rcv, drv_d, drv_q;
  logic rx_dom, xrx_dom;

  assign en      = ~en_n_i;
  assign cmp_dom = ~rx_cmp_n_i;

  for (genvar k = 0; k < NBUS; k++) begin : g_bus
    rep_rx_gate #(.REL_CYC(REL_CYC)) i_gate (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en[k]),
      .cmp_dom_i (cmp_dom[k]),
      .drv_q_i   (drv_q[k]),
      .drv_d_i   (drv_d[k]),
      .rcv_o     (rcv[k])
    );
  end

  rep_merge i_merge (
    .tx_dom_i  (~tx_n_i),
    .xtx_dom_i (~xtx_n_i),
    .en_i      (en),
    .tsd_i     (tsd_i),
    .rcv_i     (rcv),
    .drv_d_o   (drv_d),
    .rx_dom_o  (rx_dom),
    .xrx_dom_o (xrx_dom)
  );

  // registered drive breaks the bus-to-bus combinational loop
  rep_drv_reg i_drv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (drv_d),
    .q_o    (drv_q)
  );

  assign drv_n_o = ~drv_q;
  assign rx_n_o  = ~rst_ni | ~rx_dom;
  assign xrx_n_o = ~rst_ni | ~xrx_dom;
endmodule

// File: rtl/rep_chk.sv
module rep_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_n_i,
  input logic       xtx_n_i,
  input logic [1:0] en_n_i,
  input logic [1:0] rx_cmp_n_i,
  input logic       tsd_i,
  input logic [1:0] drv_n_o,
  input logic       rx_n_o,
  input logic       xrx_n_o
);
  for (genvar k = 0; k < 2; k++) begin : g_k
    a_r2_tx_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tx_n_i && !en_n_i[k] && !tsd_i) |=> !drv_n_o[k]);
    a_r4_disabled_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_n_i[k] |=> drv_n_o[k]);
  end

  a_r5_direct_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_n_i |-> (!rx_n_o && !xrx_n_o));

  a_r6_direct_xtx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xtx_n_i |-> !rx_n_o);

  a_r7_tsd_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tsd_i |=> (drv_n_o == 2'b11));

  a_r8_no_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!drv_n_o[0] && tx_n_i && xtx_n_i && rx_cmp_n_i[1]) |-> rx_n_o);

  a_r10_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (drv_n_o == 2'b11 && rx_n_o && xrx_n_o));
endmodule

bind dual_can_rep rep_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_n_i     (tx_n_i),
  .xtx_n_i    (xtx_n_i),
  .en_n_i     (en_n_i),
  .rx_cmp_n_i (rx_cmp_n_i),
  .tsd_i      (tsd_i),
  .drv_n_o    (drv_n_o),
  .rx_n_o     (rx_n_o),
  .xrx_n_o    (xrx_n_o)
);

// File: tb/test_dual_can_rep.sv
module test_dual_can_rep;
  localparam int CLK_PER = 10;
  localparam int REL     = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tx_n = 1'b1, xtx_n = 1'b1, tsd = 1'b0;
  logic [1:0] en_n = 2'b00;
  logic [1:0] ext = 2'b00;   // external node driving bus k dominant
  logic [1:0] cmp_n, drv_n;
  logic       rx_n, xrx_n;

  int n_chk = 0, n_bad = 0;
  bit m_drv[2];
  int m_hold[2];

  always #(CLK_PER/2) clk = ~clk;

  // wired bus: dominant if this block or the external node drives it
  assign cmp_n[0] = !(ext[0] || !drv_n[0]);
  assign cmp_n[1] = !(ext[1] || !drv_n[1]);

  dual_can_rep #(.REL_CYC(REL)) i_dual_can_rep (
    .clk_i(clk), .rst_ni(rst_n), .tx_n_i(tx_n), .xtx_n_i(xtx_n),
    .en_n_i(en_n), .rx_cmp_n_i(cmp_n), .tsd_i(tsd),
    .drv_n_o(drv_n), .rx_n_o(rx_n), .xrx_n_o(xrx_n));

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit heard(int k);
    return !en_n[k] && (ext[k] || m_drv[k]) && !(m_drv[k] || m_hold[k] > 0);
  endfunction

  task automatic step(input string tag);
    bit r0, r1, nx[2];
    @(posedge clk);
    if (!rst_n) begin
      m_drv = '{0, 0}; m_hold = '{0, 0};
    end else begin
      r0 = heard(0); r1 = heard(1);
      nx[0] = !en_n[0] && !tsd && (!tx_n || !xtx_n || r1);
      nx[1] = !en_n[1] && !tsd && (!tx_n || !xtx_n || r0);
      for (int k = 0; k < 2; k++) begin
        if (m_drv[k] && !nx[k]) m_hold[k] = REL;
        else if (m_hold[k] > 0) m_hold[k]--;
        m_drv[k] = nx[k];
      end
    end
    #(CLK_PER/2);
    r0 = heard(0); r1 = heard(1);
    chk(tag, "drv0", drv_n[0], rst_n ? !m_drv[0] : 1'b1);
    chk(tag, "drv1", drv_n[1], rst_n ? !m_drv[1] : 1'b1);
    chk(tag, "rx",   rx_n,  rst_n ? !(!tx_n || !xtx_n || r0 || r1) : 1'b1);
    chk(tag, "xrx",  xrx_n, rst_n ? !(!tx_n || r0 || r1) : 1'b1);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 20000);
    n_bad++;
    $display("FAIL watchdog expired t=%0t", $time);
    finish_run();
  end

  initial begin
    int pulses1, pulses0, width1;
    logic prev1, prev0;
    #1 rst_n = 1'b0;
    tx_n = 1'b0;                       // R10: reset hides traffic
    idle("R10", 3);
    tx_n = 1'b1;
    rst_n = 1'b1;
    idle("R1", 3);

    tx_n = 1'b0;    idle("R2", 3);     // R5 also checked on rx/xrx
    tx_n = 1'b1;    idle("R8", REL + 2);
    xtx_n = 1'b0;   idle("R6", 3);
    xtx_n = 1'b1;   idle("R8", REL + 2);

    en_n = 2'b10; tx_n = 1'b0; idle("R4", 3);
    tx_n = 1'b1; idle("R4", REL + 2);

    en_n = 2'b11; tx_n = 1'b0; xtx_n = 1'b0; idle("R5", 2);
    tx_n = 1'b1; idle("R6", 2);
    xtx_n = 1'b1;
    ext = 2'b01; idle("R4", 2);        // ignored receiver: outputs stay recessive
    ext = 2'b00; en_n = 2'b00; idle("R1", 2);

    tsd = 1'b1; tx_n = 1'b0; idle("R7", 3);
    tx_n = 1'b1; ext = 2'b10; idle("R7", 3);
    ext = 2'b00; tsd = 1'b0; idle("R7", 2);

    ext = 2'b10; idle("R3", 3);        // bus 1 forwarded to bus 0
    ext = 2'b00; idle("R3", REL + 2);

    // R9: one pulse on bus 0 yields one pulse on bus 1
    pulses1 = 0; pulses0 = 0; width1 = 0;
    prev1 = drv_n[1]; prev0 = drv_n[0];
    ext = 2'b01;
    for (int i = 0; i < 16; i++) begin
      if (i == 5) ext = 2'b00;
      step("R9");
      if (prev1 && !drv_n[1]) pulses1++;
      if (prev0 && !drv_n[0]) pulses0++;
      if (!drv_n[1]) width1++;
      prev1 = drv_n[1]; prev0 = drv_n[0];
    end
    n_chk++; if (pulses1 != 1) begin n_bad++; $display("FAIL R9 bus1 pulses actual=%0d expected=1", pulses1); end
    n_chk++; if (width1 != 5)  begin n_bad++; $display("FAIL R9 bus1 width actual=%0d expected=5", width1); end
    n_chk++; if (pulses0 != 0) begin n_bad++; $display("FAIL R9 bus0 pulses actual=%0d expected=0", pulses0); end
    chk("R9", "idle buses", drv_n[0] & drv_n[1], 1'b1);

    // R8: within the release window bus 1 is masked, afterwards it is heard
    ext = 2'b01; idle("R8", 3);
    ext = 2'b00; step("R8");
    ext = 2'b10; step("R8");
    chk("R8", "masked rx", rx_n, 1'b1);
    ext = 2'b00; idle("R8", REL + 1);
    ext = 2'b10; step("R8");
    chk("R8", "reopened rx", rx_n, 1'b0);
    ext = 2'b00; idle("R8", REL + 3);

    finish_run();
  end
endmodule